// File: doc/BRIEF.md
# Clock-Sampled Phase-Frequency Detector

The detector compares the rising edges of two digital waveforms, a reference and a feedback signal. It reports which of the two arrived first, and by how many clock periods. Both inputs are sampled by a fast system clock, so all timing is quantized to that clock.

When the reference edge comes first, the up output goes high at that edge and stays high until the next feedback edge. When the feedback edge comes first, the down output does the same with the roles swapped. The duty cycle of the active output therefore carries the phase error.

Edges that arrive more than a full cycle apart keep the same output asserted, which lets the block discriminate frequency as well as phase. Complemented copies of both outputs rest high. A signed width report gives each finished pulse length in clock cycles, positive for up and negative for down, for use in checking.

Top module: `pfd_sampled`

## Requirements
- R1: While the synchronous active-high reset is asserted, up and dn are 0, up_n and dn_n are 1, and width_vld is 0. After reset the block is neutral.
- R2: If a reference rising edge is seen while the block is neutral and no feedback edge is seen in the same cycle, up goes high. It returns low at the next feedback edge, so its high time in cycles equals the spacing of the two input rises. dn stays 0 for that whole time.
- R3: R2 also holds with the roles of reference/up and feedback/dn exchanged.
- R4: Rising edges of both inputs detected in the same clock cycle assert neither output and return the block to neutral.
- R5: Held input levels and falling edges have no effect on the outputs.
- R6: Two reference edges with no feedback edge between them leave the block with up active after the second edge. The same holds for two feedback edges, which leave dn active.
- R7: While up is high, further reference edges keep it high, so the pulse runs from the first reference edge to the next feedback edge. The same holds for dn with feedback edges.
- R8: up_n is always the complement of up, and dn_n is always the complement of dn.
- R9: An input rise driven just after one clock edge shows on the output after the third following clock edge. This latency comes from two synchronizer flops plus one state register.
- R10: In the cycle in which up or dn falls, width_vld is 1 for exactly one cycle and width carries the pulse length in cycles. The value is positive for up and two's-complement negative for dn.
- R11: Repeated coincident edges on both inputs (lock) never produce an active output or a width report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference waveform, asynchronous |
| fb_in | input | 1 | Feedback waveform, asynchronous |
| up | output | 1 | High while the reference leads |
| dn | output | 1 | High while the feedback leads |
| up_n | output | 1 | Complement of up, high at rest |
| dn_n | output | 1 | Complement of dn, high at rest |
| width | output | CW | Signed length of the finished pulse in cycles |
| width_vld | output | 1 | One-cycle strobe for width |

## Verification
The assertions assume that each input is seen low by at least one clock sample between two rises. Otherwise a rise is missed and edge-ordering properties would not apply. They also assume pulses shorter than the width counter's saturation limit, so that the reported length is exact.

The stimulus drives every input change half a clock away from the sampling edge. It holds each input low for at least one sample between rises, and it keeps all pulse spacings to a few cycles, far below the counter limit.

// File: rtl/pfd_sampled.sv
module pfd_sampled #(
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ref_in,
  input  logic                 fb_in,
  output logic                 up,
  output logic                 dn,
  output logic                 up_n,
  output logic                 dn_n,
  output logic signed [CW-1:0] width,
  output logic                 width_vld
);

  localparam logic [CW-1:0] CMAX = CW'((64'd1 << (CW-1)) - 64'd2);

  typedef enum logic [1:0] {NEUT, LEAD_R, LEAD_F} st_t;

  logic [SYNC:0] r_sh, f_sh;
  logic          r_edge, f_edge;
  st_t           st, nxt;
  logic [CW-1:0] cnt, cnt_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_sh <= '0;
      f_sh <= '0;
    end else begin
      r_sh <= {r_sh[SYNC-1:0], ref_in};
      f_sh <= {f_sh[SYNC-1:0], fb_in};
    end
  end

  assign r_edge = r_sh[SYNC-1] & ~r_sh[SYNC];
  assign f_edge = f_sh[SYNC-1] & ~f_sh[SYNC];

  always_comb begin
    nxt = st;
    unique case (st)
      NEUT: begin
        if (r_edge && !f_edge) nxt = LEAD_R;
        else if (f_edge && !r_edge) nxt = LEAD_F;
      end
      LEAD_R: if (f_edge) nxt = NEUT;
      LEAD_F: if (r_edge) nxt = NEUT;
      default: nxt = NEUT;
    endcase
  end

  assign cnt_inc = (cnt == CMAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= NEUT;
      cnt       <= '0;
      width     <= '0;
      width_vld <= 1'b0;
    end else begin
      st        <= nxt;
      cnt       <= (st != NEUT && nxt == st) ? cnt_inc : '0;
      width_vld <= (st != NEUT && nxt != st);
      if (st != NEUT && nxt != st)
        width <= (st == LEAD_R) ? $signed(cnt + 1'b1) : $signed(~(cnt + 1'b1) + 1'b1);
    end
  end

  assign up   = (st == LEAD_R);
  assign dn   = (st == LEAD_F);
  assign up_n = ~up;
  assign dn_n = ~dn;

  assert_excl_R2: assert property (@(posedge clk) disable iff (rst) !(up && dn));

  assert_up_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(r_edge && !f_edge));

  assert_dn_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dn) |-> $past(f_edge && !r_edge));

  assert_coincident_R4: assert property (@(posedge clk) disable iff (rst)
    (r_edge && f_edge) |=> (!up && !dn));

  assert_up_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (up && !f_edge) |=> up);

  assert_dn_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (dn && !r_edge) |=> dn);

  assert_report_R10: assert property (@(posedge clk) disable iff (rst)
    width_vld |-> ($fell(up) || $fell(dn)));

  assert_report_sign_R10: assert property (@(posedge clk) disable iff (rst)
    (width_vld && $fell(up)) |-> (width > 0));

  assert_rest_high_R8: assert property (@(posedge clk) disable iff (rst)
    (!up && !dn) |-> (up_n && dn_n));

endmodule

// File: tb/test_pfd_sampled.sv
module test_pfd_sampled;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst, ref_in, fb_in;
  logic up, dn, up_n, dn_n, width_vld;
  logic signed [CW-1:0] width;

  int errors = 0, checks = 0;
  int comp_bad = 0;
  bit act_seen = 0;
  bit done = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  pfd_sampled #(.CW(CW)) i_pfd_sampled (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .up(up), .dn(dn), .up_n(up_n), .dn_n(dn_n),
    .width(width), .width_vld(width_vld)
  );

  function automatic void chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (up_n !== ~up || dn_n !== ~dn) comp_bad++;
      if (up || dn) act_seen = 1;
      if (width_vld) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected report", int'(width), 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(width) == e, "R10 width", int'(width), e);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_r();
    ref_in = 1; step(1); ref_in = 0;
  endtask

  task automatic rise_f();
    fb_in = 1; step(1); fb_in = 0;
  endtask

  task automatic rise_both();
    ref_in = 1; fb_in = 1; step(1); ref_in = 0; fb_in = 0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; ref_in = 0; fb_in = 0;
    step(3);
    chk(up == 0 && dn == 0, "R1 up/dn", {up, dn}, 0);
    chk(up_n == 1 && dn_n == 1, "R1 up_n/dn_n", {up_n, dn_n}, 3);
    chk(width_vld == 0, "R1 width_vld", width_vld, 0);
    rst = 0;
    step(3);

    // R2 / R9: reference leads by 4
    exp_q.push_back(4);
    rise_r();
    step(1);
    chk(up == 0, "R9 up before latency", up, 0);
    step(1);
    chk(up == 1 && dn == 0, "R2 R9 up active", {up, dn}, 2);
    step(1);
    rise_f();
    step(1);
    chk(up == 1, "R2 up held until feedback", up, 1);
    step(1);
    chk(up == 0 && dn == 0, "R2 up ended", {up, dn}, 0);
    step(4);

    // R3: feedback leads by 3
    exp_q.push_back(-3);
    rise_f();
    step(2);
    chk(dn == 1 && up == 0, "R3 dn active", {up, dn}, 1);
    rise_r();
    step(5);
    chk(dn == 0, "R3 dn ended", dn, 0);

    // R4: coincident edges
    act_seen = 0;
    rise_both();
    step(6);
    chk(act_seen == 0, "R4 coincident edges", act_seen, 0);

    // R6: feedback-lead state, then two reference edges force up
    exp_q.push_back(-2);
    rise_f();
    step(1);
    rise_r();
    step(3);
    rise_r();
    step(2);
    chk(up == 1, "R6 second reference edge gives up", up, 1);
    exp_q.push_back(6);
    step(3);
    rise_f();
    step(5);

    // R6: symmetric, two feedback edges force dn
    exp_q.push_back(2);
    rise_r();
    step(1);
    rise_f();
    step(3);
    rise_f();
    step(2);
    chk(dn == 1, "R6 second feedback edge gives dn", dn, 1);
    exp_q.push_back(-5);
    step(2);
    rise_r();
    step(5);

    // R7: reference faster, up held across extra reference edges
    exp_q.push_back(9);
    rise_r(); step(2);
    rise_r(); step(1);
    chk(up == 1, "R7 up held at second edge", up, 1);
    step(1);
    rise_r(); step(2);
    chk(up == 1, "R7 up held at third edge", up, 1);
    rise_f();
    step(5);
    chk(up == 0, "R7 up ends at feedback", up, 0);

    // R5: held levels and falling edges
    exp_q.push_back(4);
    ref_in = 1;
    step(4);
    fb_in = 1;
    step(5);
    act_seen = 0;
    step(8);
    chk(act_seen == 0, "R5 held high levels", act_seen, 0);
    ref_in = 0; fb_in = 0;
    step(6);
    chk(act_seen == 0, "R5 falling edges", act_seen, 0);
    exp_q.push_back(2);
    rise_r(); step(1);
    rise_f();
    step(5);

    // R11: lock
    act_seen = 0;
    for (int i = 0; i < 5; i++) begin
      rise_both();
      step(3);
    end
    step(4);
    chk(act_seen == 0, "R11 lock no pulse", act_seen, 0);

    step(4);
    chk(exp_q.size() == 0, "R10 all reports seen", exp_q.size(), 0);
    chk(comp_bad == 0, "R8 complement outputs", comp_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule